// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of virtual-page to physical-frame mappings and answers address translation requests from them. A request presents a virtual address. The page-number part of that address is compared with every stored mapping at once. When one mapping matches, the block returns the stored frame number with the page offset of the request attached unchanged below it. When no mapping matches, the block raises a miss flag. The requester must then consult the page table and install the missing mapping through the refill port.

A refill first tries to replace an entry that already holds the same page number. If there is none, it takes the lowest-numbered empty slot. If every slot is occupied, a rotating pointer picks the slot to evict. A flush input empties the whole buffer in one cycle, for use on a context switch. Running hit and miss counters let a test compare the observed hit ratio against a known reference stream.

Top module: `xlat_tlb`

## Requirements
- R1: A lookup presented in cycle N is answered in cycle N+1. In that cycle `rsp_valid` is 1 and exactly one of `rsp_hit` and `rsp_miss` is 1. With no lookup, `rsp_valid`, `rsp_hit` and `rsp_miss` are 0.
- R2: On a hit, `rsp_paddr` is the stored frame number in bits [PFN_W+OFF_W-1:OFF_W], with the request's offset `lk_vaddr[OFF_W-1:0]` copied unchanged into bits [OFF_W-1:0].
- R3: A lookup whose page number (`lk_vaddr[VPN_W+OFF_W-1:OFF_W]`) matches no valid entry reports `rsp_miss`=1 and `rsp_hit`=0, and `rsp_paddr` is 0.
- R4: A refill of a page number that is not stored writes into the lowest-indexed invalid entry. No valid entry is evicted while an invalid entry exists.
- R5: When all entries are valid, a refill of a new page number replaces the entry selected by a rotating pointer. The pointer starts at index 0 after reset and advances by one, wrapping at ENTRIES-1, only on such evictions.
- R6: A refill of a page number that is already stored overwrites that entry's frame number. It takes no other slot, so at most one entry ever matches a page number.
- R7: A flush clears every entry in one cycle. A lookup presented in the flush cycle reports a miss.
- R8: When flush and refill are asserted in the same cycle, the flush wins and the refill is discarded.
- R9: A lookup in the same cycle as a refill sees the contents from before that refill.
- R10: `hit_count` and `miss_count` each increase by one for every hit or miss. The new count appears in the same cycle as the response.
- R11: After reset no entry is valid, both counters are 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| rf_valid | input | 1 | Refill strobe |
| rf_vpn | input | VPN_W | Page number to install |
| rf_pfn | input | PFN_W | Frame number to install |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss, page table access needed |
| rsp_paddr | output | PFN_W+OFF_W | Translated physical address (0 on miss) |
| hit_count | output | CNT_W | Number of hits since reset |
| miss_count | output | CNT_W | Number of misses since reset |

## Verification
Every lookup result and both counters change one clock after the request is captured. The bench therefore drives each request on a falling edge, lets one rising edge pass, and reads the response on the next falling edge, before anything else changes. A refill or flush takes effect at the rising edge that captures it, so the earliest lookup that can see it is the next request. Same-cycle cases (lookup with refill, lookup with flush, refill with flush) are driven together in a single cycle. Their expected results follow from the contents as they stood before that edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Where a refill lands
    typedef enum logic [1:0] {
        VIC_MATCH = 2'd0,   // same page number already stored
        VIC_FREE  = 2'd1,   // lowest empty slot
        VIC_RR    = 2'd2    // rotating eviction
    } vic_src_e;

    localparam int DEF_ENTRIES = 8;
    localparam int DEF_VPN_W   = 20;
    localparam int DEF_PFN_W   = 20;
    localparam int DEF_OFF_W   = 12;
    localparam int DEF_CNT_W   = 32;

    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [N-1:0][PFN_W-1:0] frames,
    input  logic [VPN_W-1:0]        probe,
    output logic [N-1:0]            hit_vec,
    output logic                    any_hit,
    output logic [PFN_W-1:0]        frame_out
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit_vec[g] = valid[g] && (tags[g] == probe);
        end
    endgenerate

    assign any_hit = |hit_vec;

    // At most one entry matches, so an OR of masked frames selects it
    always_comb begin
        frame_out = '0;
        for (int i = 0; i < N; i++) begin
            frame_out = frame_out | (frames[i] & {PFN_W{hit_vec[i]}});
        end
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     same_vec,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] wr_idx,
    output vic_src_e         src
);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] same_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        same_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (same_vec[i]) begin
                same_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (|same_vec) begin
            src    = VIC_MATCH;
            wr_idx = same_idx;
        end else if (free_found) begin
            src    = VIC_FREE;
            wr_idx = free_idx;
        end else begin
            src    = VIC_RR;
            wr_idx = rr_ptr;
        end
    end

endmodule

// File: rtl/xlat_counters.sv
module xlat_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_hit,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] hits,
    output logic [CNT_W-1:0] misses
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hits   <= '0;
            misses <= '0;
        end else begin
            if (inc_hit)  hits   <= hits + CNT_W'(1);
            if (inc_miss) misses <= misses + CNT_W'(1);
        end
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int VPN_W   = DEF_VPN_W,
    parameter int PFN_W   = DEF_PFN_W,
    parameter int OFF_W   = DEF_OFF_W,
    parameter int CNT_W   = DEF_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lk_valid,
    input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input  logic                   rf_valid,
    input  logic [VPN_W-1:0]       rf_vpn,
    input  logic [PFN_W-1:0]       rf_pfn,
    input  logic                   flush,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_miss,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic [CNT_W-1:0]       hit_count,
    output logic [CNT_W-1:0]       miss_count
);

    localparam int IDX_W = idx_bits(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    // Entry storage
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
    logic [ENTRIES-1:0][PFN_W-1:0] frame_q;
    logic [IDX_W-1:0]              rr_q;

    // Lookup side
    logic [VPN_W-1:0]   look_vpn;
    logic [OFF_W-1:0]   look_off;
    logic [ENTRIES-1:0] look_hit_vec;
    logic               look_any;
    logic [PFN_W-1:0]   look_frame;
    logic               take_hit;
    logic               take_miss;

    // Refill side
    logic [ENTRIES-1:0] fill_same_vec;
    logic               fill_same_any;
    logic [PFN_W-1:0]   fill_unused_frame;
    logic [IDX_W-1:0]   fill_idx;
    vic_src_e           fill_src;

    assign look_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];
    assign look_off = lk_vaddr[OFF_W-1:0];

    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_look (
        .valid     (valid_q),
        .tags      (tag_q),
        .frames    (frame_q),
        .probe     (look_vpn),
        .hit_vec   (look_hit_vec),
        .any_hit   (look_any),
        .frame_out (look_frame)
    );

    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_fill_cmp (
        .valid     (valid_q),
        .tags      (tag_q),
        .frames    (frame_q),
        .probe     (rf_vpn),
        .hit_vec   (fill_same_vec),
        .any_hit   (fill_same_any),
        .frame_out (fill_unused_frame)
    );

    xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid    (valid_q),
        .same_vec (fill_same_vec),
        .rr_ptr   (rr_q),
        .wr_idx   (fill_idx),
        .src      (fill_src)
    );

    // A flush in the same cycle forces the lookup to miss
    assign take_hit  = lk_valid && !flush && look_any;
    assign take_miss = lk_valid && !take_hit;

    // Valid bits and eviction pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (rf_valid) begin
            valid_q[fill_idx] <= 1'b1;
            if (fill_src == VIC_RR) begin
                rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + IDX_W'(1);
            end
        end
    end

    // Tag and frame payload, no reset needed
    always_ff @(posedge clk) begin
        if (!rst && !flush && rf_valid) begin
            tag_q[fill_idx]   <= rf_vpn;
            frame_q[fill_idx] <= rf_pfn;
        end
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= take_hit;
            rsp_miss  <= take_miss;
            rsp_paddr <= take_hit ? {look_frame, look_off} : '0;
        end
    end

    xlat_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .inc_hit  (take_hit),
        .inc_miss (take_miss),
        .hits     (hit_count),
        .misses   (miss_count)
    );

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int CNT_W   = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   lk_valid,
    input logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input logic                   flush,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic                   rsp_miss,
    input logic [PFN_W+OFF_W-1:0] rsp_paddr,
    input logic [CNT_W-1:0]       hit_count,
    input logic [CNT_W-1:0]       miss_count,
    input logic [ENTRIES-1:0]     look_hit_vec
);

    logic [CNT_W-1:0] total;
    assign total = hit_count + miss_count;

    // R1: one response per lookup, hit and miss exclusive
    assert_one_outcome_R1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (rsp_valid && (rsp_hit != rsp_miss)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

    // R2: offset copied through on a hit
    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R6: never more than one matching entry
    assert_single_match_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_hit_vec));

    // R7: lookup during flush, and the one right after, miss
    assert_flush_miss_R7: assert property (@(posedge clk) disable iff (rst)
        (flush && lk_valid) |=> rsp_miss);

    assert_after_flush_R7: assert property (@(posedge clk) disable iff (rst)
        flush ##1 lk_valid |=> rsp_miss);

    // R10: counters advance by one per lookup
    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (total == $past(total) + CNT_W'(1)));

    assert_count_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> $stable(total));

endmodule

bind xlat_tlb xlat_tlb_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .OFF_W   (OFF_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .lk_valid     (lk_valid),
    .lk_vaddr     (lk_vaddr),
    .flush        (flush),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_paddr    (rsp_paddr),
    .hit_count    (hit_count),
    .miss_count   (miss_count),
    .look_hit_vec (look_hit_vec)
);

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;

    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int OFF_W = 12;
    localparam int CNT_W = 32;
    localparam int NVEC  = 10;
    localparam int VEC_W = 2 + VPN_W + PFN_W + OFF_W + 1;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   lk_valid = 1'b0;
    logic [VPN_W+OFF_W-1:0] lk_vaddr = '0;
    logic                   rf_valid = 1'b0;
    logic [VPN_W-1:0]       rf_vpn = '0;
    logic [PFN_W-1:0]       rf_pfn = '0;
    logic                   flush = 1'b0;
    logic                   rsp_valid, rsp_hit, rsp_miss;
    logic [PFN_W+OFF_W-1:0] rsp_paddr;
    logic [CNT_W-1:0]       hit_count, miss_count;

    int checks = 0;
    int failures = 0;
    int exp_hits = 0;
    int exp_miss = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlat_tlb #(.ENTRIES(8), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr), .hit_count(hit_count), .miss_count(miss_count)
    );

    // Vector: {op(0 lookup,1 refill), vpn, pfn, offset, expected hit}
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {2'd0, 20'h00005, 20'h00000, 12'hABC, 1'b0},
        {2'd1, 20'h00005, 20'h00111, 12'h000, 1'b0},
        {2'd0, 20'h00005, 20'h00111, 12'hABC, 1'b1},
        {2'd1, 20'h00009, 20'h00222, 12'h000, 1'b0},
        {2'd0, 20'h00009, 20'h00222, 12'h000, 1'b1},
        {2'd0, 20'h00005, 20'h00111, 12'h001, 1'b1},
        {2'd1, 20'h00005, 20'h00333, 12'h000, 1'b0},
        {2'd0, 20'h00005, 20'h00333, 12'hFFF, 1'b1},
        {2'd0, 20'h00007, 20'h00000, 12'h123, 1'b0},
        {2'd0, 20'h00009, 20'h00222, 12'h7FF, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; on return the registered response is visible
    task automatic step(input bit lk, input logic [VPN_W-1:0] lvpn, input logic [OFF_W-1:0] loff,
                        input bit rf, input logic [VPN_W-1:0] rvpn, input logic [PFN_W-1:0] rpfn,
                        input bit fl);
        @(negedge clk);
        lk_valid = lk;
        lk_vaddr = {lvpn, loff};
        rf_valid = rf;
        rf_vpn   = rvpn;
        rf_pfn   = rpfn;
        flush    = fl;
        @(negedge clk);
        lk_valid = 1'b0;
        rf_valid = 1'b0;
        flush    = 1'b0;
    endtask

    task automatic verify(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                          input bit exp_hit, input logic [PFN_W-1:0] exp_pfn, input string req);
        logic [PFN_W+OFF_W-1:0] exp_pa;
        exp_pa = exp_hit ? {exp_pfn, off} : '0;
        if (exp_hit) exp_hits++; else exp_miss++;
        check(rsp_valid && (rsp_hit == exp_hit) && (rsp_miss == !exp_hit),
              {req, " outcome"}, {61'd0, rsp_valid, rsp_hit, rsp_miss},
              {61'd0, 1'b1, exp_hit, !exp_hit});
        check(rsp_paddr == exp_pa, {req, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
        if (vpn == '0) begin end
    endtask

    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                          input bit exp_hit, input logic [PFN_W-1:0] exp_pfn, input string req);
        step(1'b1, vpn, off, 1'b0, '0, '0, 1'b0);
        verify(vpn, off, exp_hit, exp_pfn, req);
    endtask

    task automatic refill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn);
        step(1'b0, '0, '0, 1'b1, vpn, pfn, 1'b0);
    endtask

    task automatic check_counts(input string req);
        check(hit_count == CNT_W'(exp_hits), {req, " hit_count"}, 64'(hit_count), 64'(exp_hits));
        check(miss_count == CNT_W'(exp_miss), {req, " miss_count"}, 64'(miss_count), 64'(exp_miss));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check(!rsp_valid && !rsp_hit && !rsp_miss, "R11 response idle",
              {61'd0, rsp_valid, rsp_hit, rsp_miss}, 64'd0);
        check(hit_count == '0 && miss_count == '0, "R11 counters zero",
              64'(hit_count + miss_count), 64'd0);
        lookup(20'h00005, 12'h000, 1'b0, '0, "R11 empty after reset");
        // R1 idle cycle: no lookup means no response
        @(negedge clk);
        check(!rsp_valid && !rsp_hit && !rsp_miss, "R1 no lookup no response",
              {61'd0, rsp_valid, rsp_hit, rsp_miss}, 64'd0);

        // Table walk: R1 R2 R3 R6
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]       op;
            logic [VPN_W-1:0] vv;
            logic [PFN_W-1:0] pp;
            logic [OFF_W-1:0] oo;
            logic             hh;
            {op, vv, pp, oo, hh} = VEC[i];
            if (op == 2'd1) refill(vv, pp);
            else lookup(vv, oo, hh, pp, hh ? "R2 table hit" : "R3 table miss");
        end
        check_counts("R10 after table");

        // R4: fill remaining six slots, nothing evicted (5 and 9 already held)
        for (int k = 0; k < 6; k++) refill(VPN_W'(32'h100 + k), PFN_W'(32'h500 + k));
        lookup(20'h00005, 12'h010, 1'b1, 20'h00333, "R4 first entry kept");
        lookup(20'h00009, 12'h020, 1'b1, 20'h00222, "R4 second entry kept");
        for (int k = 0; k < 6; k++)
            lookup(VPN_W'(32'h100 + k), 12'h030, 1'b1, PFN_W'(32'h500 + k), "R4 fill into free");

        // R5/R6: full buffer, eviction starts at index 0 (held vpn 5)
        refill(20'h00200, 20'h00AAA);
        lookup(20'h00005, 12'h040, 1'b0, '0, "R5 index0 evicted R6 no duplicate");
        lookup(20'h00009, 12'h050, 1'b1, 20'h00222, "R5 index1 kept");
        lookup(20'h00200, 12'h060, 1'b1, 20'h00AAA, "R5 new entry");
        refill(20'h00201, 20'h00BBB);
        lookup(20'h00009, 12'h070, 1'b0, '0, "R5 pointer advanced to index1");
        lookup(20'h00100, 12'h080, 1'b1, 20'h00500, "R5 index2 kept");

        // R9: lookup in the refill cycle sees old contents
        step(1'b1, 20'h00300, 12'h090, 1'b1, 20'h00300, 20'h00CCC, 1'b0);
        verify(20'h00300, 12'h090, 1'b0, '0, "R9 lookup during refill");
        lookup(20'h00300, 12'h091, 1'b1, 20'h00CCC, "R9 visible next cycle");
        lookup(20'h00100, 12'h092, 1'b0, '0, "R5 index2 evicted third");

        // R7: flush with simultaneous lookup of a held page
        step(1'b1, 20'h00300, 12'h0A0, 1'b0, '0, '0, 1'b1);
        verify(20'h00300, 12'h0A0, 1'b0, '0, "R7 lookup during flush");
        lookup(20'h00201, 12'h0A1, 1'b0, '0, "R7 flushed entry gone");
        lookup(20'h00101, 12'h0A2, 1'b0, '0, "R7 flushed entry gone");

        // R8: flush wins over refill
        refill(20'h00400, 20'h00DDD);
        step(1'b0, '0, '0, 1'b1, 20'h00401, 20'h00EEE, 1'b1);
        lookup(20'h00401, 12'h0B0, 1'b0, '0, "R8 refill discarded");
        lookup(20'h00400, 12'h0B1, 1'b0, '0, "R8 flush cleared prior entry");
        refill(20'h00500, 20'h00FFF);
        lookup(20'h00500, 12'h0B2, 1'b1, 20'h00FFF, "R4 refill after flush");

        check_counts("R10 final");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule